// File: doc/BRIEF.md
# Hop-Addressed Indirect Configuration Bridge

The bridge lets a host reach configuration registers that sit in several hop-addressed units through two memory-mapped words. One is a data word at byte offset 0x0 and the other is a command word at byte offset 0x4. For a write, the host loads the data word first and then writes the command word. Writing the command word starts the operation.

The bridge decodes the stored command into five things: a sub-operation, a local/remote flag, a destination hop, an address space and a register offset. It then sends one request pulse on a simple internal register bus. When the unit answers, the bridge raises a done flag in the command word. For a read it also copies the returned value into the data word and raises a read-ready flag in the same cycle. The host therefore polls the command word until done is set, and for a read until both done and read-ready are set.

A remote request can go unanswered. If no response arrives within a programmable number of cycles, the bridge ends the operation with done set and a timeout flag set, so host polling always stops. A command written while another is in flight is dropped and recorded in a sticky error flag.

Top module: `cfg_hop_bridge`

## Requirements
- R1: After reset, both the data word and the command word read as zero, and `req_valid` is low.
- R2: A host write at byte offset 0x0 loads the data word, and a read there returns it. A data write made while an operation is in flight is ignored. A write to any offset other than 0x0 or 0x4 changes nothing, and a read from such an offset returns zero.
- R3: An accepted write at offset 0x4 drives `req_valid` high for exactly one cycle, in the cycle after the write. The same write clears the done flag (bit 6) and the read-ready flag (bit 7).
- R4: Bits [3:0] of the command give the sub-operation code on `req_op`: 0 is register write, 1 is register read, 2 is ID-assignment request and 3 is write at both link ends. `req_wdata` carries the data word.
- R5: Command bit 5 set marks a local access and clear marks a remote access; it appears on `req_local`. Bits [15:8] give the destination hop (0 pipe unit, 1 host-side unit, 2 far-side unit) and appear on `req_hop`.
- R6: Command bits [23:22] select the address space: 3 is PHY space and 0 is controller space. The space appears on `req_space`. `req_offset` is {`phy_off_hi`, command bits [21:16]} in PHY space and {2'b00, bits [21:16]} in any other space.
- R7: A response sets the done flag. For sub-operation 1, the same cycle loads `rsp_rdata` into the data word and sets read-ready. For any other sub-operation, read-ready stays clear and the data word is left unchanged.
- R8: A command write during an operation is ignored: no new request is sent and the stored fields stay as they were. It sets the sticky overlap flag (bit 25). That flag is cleared only by an accepted command write that has bit 25 set.
- R9: A remote operation that gets no response after `tmo_limit`+1 waiting cycles ends with done set, the timeout flag (bit 24) set and read-ready clear. A local operation never times out.
- R10: The command word reads back as: sub-operation, local flag, done, read-ready, hop, offset bits and space in their written positions, bit 24 timeout, bit 25 overlap, and zero in bits 4 and 31..26. Host-written values of bits 4, 6, 7 and 24 are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for `host_addr` |
| phy_off_hi | input | 2 | Top two offset bits for PHY-space accesses |
| tmo_limit | input | TMO_W | Remote response timeout in cycles |
| req_valid | output | 1 | One-cycle request pulse |
| req_op | output | 4 | Sub-operation code |
| req_local | output | 1 | 1 = local unit, 0 = remote side |
| req_hop | output | 8 | Destination hop |
| req_space | output | 2 | Address space |
| req_offset | output | 8 | Register offset |
| req_wdata | output | 32 | Data word for the request |
| rsp_valid | input | 1 | Response strobe from the unit |
| rsp_rdata | input | 32 | Read data returned with the response |

## Verification
The assertions assume that a unit answers only while the bridge is waiting. They assume at most one response per request, and no response in the same cycle as the request pulse. The stimulus keeps to this by raising `rsp_valid` at least one cycle after the pulse, and only once per request. The stimulus also keeps `phy_off_hi` and `tmo_limit` steady while an operation is in flight. Overlapping command writes and data writes are made only in controlled windows: during the request cycle and during the wait.

// File: rtl/cfg_hop_pkg.sv
package cfg_hop_pkg;
    localparam int WORD_W    = 32;
    localparam int OP_W      = 4;
    localparam int HOP_W     = 8;
    localparam int OFF_LO_W  = 6;
    localparam int OFF_HI_W  = 2;
    localparam int OFF_W     = OFF_LO_W + OFF_HI_W;
    localparam int SPACE_W   = 2;
    localparam int KEEP_W    = 24;

    localparam int BYTE_DATA = 0;
    localparam int BYTE_CMD  = 4;

    localparam int LOCAL_BIT = 5;
    localparam int DONE_BIT  = 6;
    localparam int RDY_BIT   = 7;
    localparam int HOP_LSB   = 8;
    localparam int OFF_LSB   = 16;
    localparam int SPACE_LSB = 22;
    localparam int TMO_BIT   = 24;
    localparam int OVL_BIT   = 25;

    localparam logic [KEEP_W-1:0]  KEEP_MASK = 24'hFFFF2F;
    localparam logic [OP_W-1:0]    OP_READ   = 4'd1;
    localparam logic [SPACE_W-1:0] SPACE_PHY = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } hop_st_e;
endpackage

// File: rtl/cfg_hop_decode.sv
module cfg_hop_decode
    import cfg_hop_pkg::*;
(
    input  logic [KEEP_W-1:0]   cmd_word,
    input  logic [OFF_HI_W-1:0] off_hi,
    output logic [OP_W-1:0]     op,
    output logic                is_local,
    output logic [HOP_W-1:0]    hop,
    output logic [SPACE_W-1:0]  space,
    output logic [OFF_W-1:0]    offset
);
    logic [OFF_LO_W-1:0] off_lo;

    always_comb begin
        op       = cmd_word[OP_W-1:0];
        is_local = cmd_word[LOCAL_BIT];
        hop      = cmd_word[HOP_LSB +: HOP_W];
        space    = cmd_word[SPACE_LSB +: SPACE_W];
        off_lo   = cmd_word[OFF_LSB +: OFF_LO_W];
        if (space == SPACE_PHY) begin
            offset = {off_hi, off_lo};
        end else begin
            offset = {{OFF_HI_W{1'b0}}, off_lo};
        end
    end
endmodule

// File: rtl/cfg_hop_timer.sv
module cfg_hop_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             hit
);
    logic [TMO_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = run ? cnt_q + 1'b1 : '0;
        hit   = run && (cnt_q == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/cfg_hop_bridge.sv
module cfg_hop_bridge
    import cfg_hop_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int TMO_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_we,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [WORD_W-1:0]   host_wdata,
    output logic [WORD_W-1:0]   host_rdata,
    input  logic [OFF_HI_W-1:0] phy_off_hi,
    input  logic [TMO_W-1:0]    tmo_limit,
    output logic                req_valid,
    output logic [OP_W-1:0]     req_op,
    output logic                req_local,
    output logic [HOP_W-1:0]    req_hop,
    output logic [SPACE_W-1:0]  req_space,
    output logic [OFF_W-1:0]    req_offset,
    output logic [WORD_W-1:0]   req_wdata,
    input  logic                rsp_valid,
    input  logic [WORD_W-1:0]   rsp_rdata
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(BYTE_DATA);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(BYTE_CMD);

    typedef struct packed {
        hop_st_e           st;
        logic [KEEP_W-1:0] cmd;
        logic [WORD_W-1:0] data;
        logic              done;
        logic              rdy;
        logic              tmo;
        logic              ovl;
    } bridge_t;

    bridge_t st_d, st_q;

    logic              wr_data, wr_cmd, busy, in_wait, tmo_hit;
    logic [OP_W-1:0]   dec_op;
    logic              dec_local;
    logic [WORD_W-1:0] status_w;

    cfg_hop_decode u_dec (
        .cmd_word (st_q.cmd),
        .off_hi   (phy_off_hi),
        .op       (dec_op),
        .is_local (dec_local),
        .hop      (req_hop),
        .space    (req_space),
        .offset   (req_offset)
    );

    cfg_hop_timer #(.TMO_W(TMO_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_wait),
        .limit (tmo_limit),
        .hit   (tmo_hit)
    );

    always_comb begin
        st_d     = st_q;
        busy     = (st_q.st != ST_IDLE);
        in_wait  = (st_q.st == ST_WAIT);
        wr_data  = host_we && (host_addr == A_DATA);
        wr_cmd   = host_we && (host_addr == A_CMD);

        if (wr_data && !busy) begin
            st_d.data = host_wdata;
        end

        if (wr_cmd) begin
            if (busy) begin
                st_d.ovl = 1'b1;
            end else begin
                st_d.cmd  = host_wdata[KEEP_W-1:0] & KEEP_MASK;
                st_d.done = 1'b0;
                st_d.rdy  = 1'b0;
                st_d.tmo  = 1'b0;
                if (host_wdata[OVL_BIT]) begin
                    st_d.ovl = 1'b0;
                end
                st_d.st   = ST_ISSUE;
            end
        end

        case (st_q.st)
            ST_ISSUE: st_d.st = ST_WAIT;
            ST_WAIT: begin
                if (rsp_valid) begin
                    st_d.done = 1'b1;
                    st_d.st   = ST_IDLE;
                    if (dec_op == OP_READ) begin
                        st_d.data = rsp_rdata;
                        st_d.rdy  = 1'b1;
                    end
                end else if (!dec_local && tmo_hit) begin
                    st_d.done = 1'b1;
                    st_d.tmo  = 1'b1;
                    st_d.st   = ST_IDLE;
                end
            end
            default: ;
        endcase

        status_w = {6'b0, st_q.ovl, st_q.tmo, st_q.cmd[KEEP_W-1:HOP_LSB],
                    st_q.rdy, st_q.done, st_q.cmd[LOCAL_BIT:0]};

        if (host_addr == A_DATA) begin
            host_rdata = st_q.data;
        end else if (host_addr == A_CMD) begin
            host_rdata = status_w;
        end else begin
            host_rdata = '0;
        end

        req_valid = (st_q.st == ST_ISSUE);
        req_op    = dec_op;
        req_local = dec_local;
        req_wdata = st_q.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/cfg_hop_bridge_chk.sv
module cfg_hop_bridge_chk #(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_we,
    input logic [ADDR_W-1:0] host_addr,
    input logic              busy,
    input logic              in_wait,
    input logic              req_valid,
    input logic              rsp_valid,
    input logic [31:0]       status_w
);
    localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(4);

    AST_REQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid); // R3

    AST_LAUNCH_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == A_CMD && !busy) |=> (req_valid && !status_w[6] && !status_w[7])); // R3

    AST_RDY_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        status_w[7] |-> status_w[6]); // R7

    AST_RSP_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && rsp_valid) |=> status_w[6]); // R7

    AST_OVERLAP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == A_CMD && busy) |=> status_w[25]); // R8

    AST_TMO_REMOTE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        status_w[24] |-> (!status_w[5] && status_w[6])); // R9
endmodule

bind cfg_hop_bridge cfg_hop_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_we   (host_we),
    .host_addr (host_addr),
    .busy      (busy),
    .in_wait   (in_wait),
    .req_valid (req_valid),
    .rsp_valid (rsp_valid),
    .status_w  (status_w)
);

// File: tb/cfg_hop_bridge_test.sv
`timescale 1ns/1ps
module cfg_hop_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [1:0]  phy_off_hi = '0;
    logic [15:0] tmo_limit = 16'd20;
    logic        req_valid;
    logic [3:0]  req_op;
    logic        req_local;
    logic [7:0]  req_hop;
    logic [1:0]  req_space;
    logic [7:0]  req_offset;
    logic [31:0] req_wdata;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_rdata = '0;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    cfg_hop_bridge uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = v;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hread(input logic [2:0] a, output logic [31:0] v);
        host_addr = a;
        #0.5;
        v = host_rdata;
    endtask

    task automatic respond(input int d, input logic [31:0] rd);
        repeat (d) @(negedge clk);
        rsp_valid = 1'b1; rsp_rdata = rd;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    function automatic logic [31:0] exp_stat(input logic [31:0] c, input logic rdy,
                                             input logic done, input logic tmo, input logic ovl);
        return {6'b0, ovl, tmo, c[23:8], rdy, done, c[5], 1'b0, c[3:0]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, cmd, wdat, rdat, cmdA;
        logic [7:0]  off6, eoff;
        logic [1:0]  sp;
        int idx;

        repeat (3) @(negedge clk);
        hread(3'd0, v); chk("R1 data after reset", v, 32'h0);
        hread(3'd4, v); chk("R1 cmd after reset", v, 32'h0);
        chk("R1 req_valid after reset", {31'b0, req_valid}, 32'h0);
        rst_n = 1'b1;

        hwrite(3'd0, 32'h1234_5678);
        hread(3'd0, v); chk("R2 data word load", v, 32'h1234_5678);
        hwrite(3'd2, 32'hFFFF_FFFF);
        hread(3'd2, v); chk("R2 unmapped read", v, 32'h0);
        hread(3'd0, v); chk("R2 unmapped write data", v, 32'h1234_5678);
        hread(3'd4, v); chk("R2 unmapped write cmd", v, 32'h0);
        chk("R2 unmapped write no req", {31'b0, req_valid}, 32'h0);

        // Sweep over operation, locality, hop, space: R3 R4 R5 R6 R7 R10
        idx = 0;
        for (int op = 0; op < 4; op++) begin
            for (int loc = 0; loc < 2; loc++) begin
                for (int hop = 0; hop < 3; hop++) begin
                    for (int s = 0; s < 2; s++) begin
                        sp   = (s != 0) ? 2'b11 : 2'b00;
                        off6 = 8'((op * 11 + hop * 5 + s * 29 + loc * 17 + idx) & 63);
                        phy_off_hi = 2'((op + hop + idx) & 3);
                        wdat = {8'h5A, 8'(idx), 16'(idx * 37 + 1)};
                        rdat = {8'(hop), 2'(sp), off6[5:0], 16'hC0DE} ^ 32'(idx);
                        // bits 4,6,7,24 set by host must not be stored (R10)
                        cmd  = {8'h01, sp, off6[5:0], 8'(hop), 2'b11, 1'(loc), 1'b1, 4'(op)};
                        hwrite(3'd0, wdat);
                        hwrite(3'd4, cmd);
                        chk("R3 req pulse", {31'b0, req_valid}, 32'h1);
                        chk("R4 req_op", {28'b0, req_op}, 32'(op));
                        chk("R4 req_wdata", req_wdata, wdat);
                        chk("R5 req_local", {31'b0, req_local}, 32'(loc));
                        chk("R5 req_hop", {24'b0, req_hop}, 32'(hop));
                        chk("R6 req_space", {30'b0, req_space}, {30'b0, sp});
                        eoff = (sp == 2'b11) ? {phy_off_hi, off6[5:0]} : {2'b00, off6[5:0]};
                        chk("R6 req_offset", {24'b0, req_offset}, {24'b0, eoff});
                        hread(3'd4, v);
                        chk("R3 flags cleared", v, exp_stat(cmd, 1'b0, 1'b0, 1'b0, 1'b0));
                        repeat (1 + idx % 3) @(negedge clk);
                        chk("R3 single pulse", {31'b0, req_valid}, 32'h0);
                        rsp_valid = 1'b1; rsp_rdata = rdat;
                        @(negedge clk);
                        rsp_valid = 1'b0;
                        hread(3'd4, v);
                        chk("R7 R10 status", v, exp_stat(cmd, op == 1, 1'b1, 1'b0, 1'b0));
                        hread(3'd0, v);
                        chk("R7 data word", v, (op == 1) ? rdat : wdat);
                        idx++;
                    end
                end
            end
        end

        // Overlapping command and busy data write: R8 R2
        hwrite(3'd0, 32'hAAAA_0001);
        cmdA = {8'h00, 2'b00, 6'd9, 8'd1, 2'b00, 1'b0, 1'b0, 4'd0};
        hwrite(3'd4, cmdA);
        hwrite(3'd4, {8'h00, 2'b11, 6'd3, 8'd2, 2'b00, 1'b1, 1'b0, 4'd1});
        chk("R8 no second request", {31'b0, req_valid}, 32'h0);
        hwrite(3'd0, 32'hDEAD_BEEF);
        chk("R8 no request later", {31'b0, req_valid}, 32'h0);
        hread(3'd4, v);
        chk("R8 fields kept, flag set", v, exp_stat(cmdA, 1'b0, 1'b0, 1'b0, 1'b1));
        respond(0, 32'h0);
        hread(3'd4, v);
        chk("R8 done with sticky flag", v, exp_stat(cmdA, 1'b0, 1'b1, 1'b0, 1'b1));
        hread(3'd0, v); chk("R2 busy data write ignored", v, 32'hAAAA_0001);
        hwrite(3'd4, cmdA);
        respond(1, 32'h0);
        hread(3'd4, v);
        chk("R8 flag survives plain command", v, exp_stat(cmdA, 1'b0, 1'b1, 1'b0, 1'b1));
        hwrite(3'd4, cmdA | 32'h0200_0000);
        respond(1, 32'h0);
        hread(3'd4, v);
        chk("R8 flag cleared by bit 25", v, exp_stat(cmdA, 1'b0, 1'b1, 1'b0, 1'b0));

        // Remote timeout with a short limit: R9
        for (int lim = 2; lim < 8; lim += 5) begin
            tmo_limit = 16'(lim);
            cmd = {8'h00, 2'b11, 6'd5, 8'd2, 2'b00, 1'b0, 1'b0, 4'd1};
            hwrite(3'd4, cmd);
            repeat (lim + 1) @(negedge clk);
            hread(3'd4, v);
            chk("R9 not yet timed out", v, exp_stat(cmd, 1'b0, 1'b0, 1'b0, 1'b0));
            @(negedge clk);
            hread(3'd4, v);
            chk("R9 remote timeout", v, exp_stat(cmd, 1'b0, 1'b1, 1'b1, 1'b0));
        end

        // Local access never times out: R9
        tmo_limit = 16'd3;
        cmd = {8'h00, 2'b00, 6'd1, 8'd0, 2'b00, 1'b1, 1'b0, 4'd1};
        hwrite(3'd4, cmd);
        repeat (15) @(negedge clk);
        hread(3'd4, v);
        chk("R9 local waits", v, exp_stat(cmd, 1'b0, 1'b0, 1'b0, 1'b0));
        respond(0, 32'h0BAD_F00D);
        hread(3'd4, v);
        chk("R9 local completes", v, exp_stat(cmd, 1'b1, 1'b1, 1'b0, 1'b0));
        hread(3'd0, v);
        chk("R7 local read data", v, 32'h0BAD_F00D);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule